// File: doc/BRIEF.md
# Interval-Gated Edge Counter

This block measures the frequency of a slow digital input. It counts rising edges of that input over a gate of a programmable number of system clocks. When the gate closes, it stores the count in a result register and opens the next gate in the same cycle, so no edge falls into a gap between gates. Software reads the result once per gate and divides by the gate length to get a frequency. For example, a gate of 200,000,000 clocks at 200 MHz gives a one-second reading.

An edge that is detected in the same cycle as the gate boundary counts as the first edge of the new gate. It is never lost and never counted twice. A gate length of zero selects a free-running mode. In that mode the count is never cleared and can be watched live. The input is asynchronous and passes through a two-flop synchronizer and a rising-edge detector before it reaches the counter.

Top module: `gated_edge_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o`, `live_count_o`, `valid_o` and `overrun_o` all become zero.
- R2: With a non-zero gate length P, a store happens every P clocks. Each store copies the edge count of the gate that is ending into `result_o` and sets `valid_o`.
- R3: An edge detected in the boundary cycle starts the new gate's count at 1 instead of 0. The sum of all stored results plus the final live count equals the number of rising edges on `sig_in`.
- R4: A rising edge of `sig_in` that is set up before clock edge k shows in `live_count_o` after clock edge k+2. A level held high counts once, and falling edges are not counted.
- R5: A gate length of zero makes the 32-bit count accumulate without clearing and wrap modulo 2^32. No stores happen in this mode.
- R6: A one-cycle `rd_ack` pulse clears `valid_o`. If a store happens in the same cycle as the read, the store wins and `valid_o` stays set.
- R7: A store while `valid_o` is set and not being read sets `overrun_o`, which stays set until reset. The new result replaces the unread one.
- R8: A change of `period_in` takes effect at the next gate boundary. The gate already running keeps its old length.
- R9: While `enable` is low, `live_count_o` is held at zero and no store happens. `result_o` and `valid_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous input whose rising edges are counted |
| enable | input | 1 | Run control; low clears the count and timer |
| period_in | input | 32 | Gate length in clocks; zero selects free-running mode |
| rd_ack | input | 1 | Read strobe; clears the valid flag |
| result_o | output | 32 | Edge count of the last completed gate |
| live_count_o | output | 32 | Running edge count of the current gate or the free-running total |
| valid_o | output | 1 | An unread result is present |
| overrun_o | output | 1 | Sticky flag: an unread result was overwritten |

## Verification
An input rise appears in the live count three clock edges after it is driven. The directed latency check samples at exactly that edge, and at the two edges before it. A store shows in `result_o` and `valid_o` right after the clock edge that ends the gate. The boundary-spacing checks therefore count edges between observed rising edges of `valid_o`. A cycle model inside the bench is updated on the same clock edges as the design from the same input values. Its outputs are compared with the design's at every falling edge, so every output is checked in the cycle it is due.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic [1:0] {
    GEC_OFF   = 2'd0,
    GEC_FREE  = 2'd1,
    GEC_GATED = 2'd2
  } gec_mode_e;
endpackage

// File: rtl/gec_sync_edge.sv
module gec_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise_o
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  // First stage samples the pin; later stages retime it.
  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= sig_in;
  end

  for (genvar g = 1; g < CHAIN; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= 1'b0;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/gec_interval_timer.sv
module gec_interval_timer
  import gec_pkg::*;
#(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [TMR_W-1:0] period_in,
  output gec_mode_e        mode_o,
  output logic             boundary_o,
  output logic             next_free_o
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] len_q;
  logic [TMR_W-1:0] tick_q;

  always_comb begin
    if (!enable)         mode_o = GEC_OFF;
    else if (len_q == '0) mode_o = GEC_FREE;
    else                 mode_o = GEC_GATED;
  end

  assign boundary_o  = (mode_o == GEC_GATED) && (tick_q == len_q - ONE);
  assign next_free_o = (period_in == '0);

  // The gate length is only taken from period_in on a reload.
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      tick_q <= '0;
    end else if (mode_o != GEC_GATED || boundary_o) begin
      len_q  <= period_in;
      tick_q <= '0;
    end else begin
      tick_q <= tick_q + ONE;
    end
  end
endmodule

// File: rtl/gec_edge_accum.sv
module gec_edge_accum
  import gec_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  gec_mode_e        mode_i,
  input  logic             boundary_i,
  input  logic             next_free_i,
  input  logic             rise_i,
  input  logic             rd_ack,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             overrun_o
);
  logic [CNT_W-1:0] inc;
  logic             store;

  assign inc   = {{(CNT_W-1){1'b0}}, rise_i};
  assign store = (mode_i == GEC_GATED) && boundary_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else begin
      unique case (mode_i)
        GEC_OFF:   count_o <= '0;
        GEC_FREE:  count_o <= next_free_i ? count_o + inc : inc;
        GEC_GATED: count_o <= boundary_i ? inc : count_o + inc;
        default:   count_o <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else if (store) begin
      result_o <= count_o;
      valid_o  <= 1'b1;
      if (valid_o && !rd_ack) overrun_o <= 1'b1;
    end else if (rd_ack) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/gated_edge_counter.sv
module gated_edge_counter
  import gec_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned TMR_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic             enable,
  input  logic [TMR_W-1:0] period_in,
  input  logic             rd_ack,
  output logic [CNT_W-1:0] result_o,
  output logic [CNT_W-1:0] live_count_o,
  output logic             valid_o,
  output logic             overrun_o
);
  logic      rise;
  logic      boundary;
  logic      next_free;
  gec_mode_e mode;

  gec_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sig_in (sig_in),
    .rise_o (rise)
  );

  gec_interval_timer #(.TMR_W(TMR_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .period_in   (period_in),
    .mode_o      (mode),
    .boundary_o  (boundary),
    .next_free_o (next_free)
  );

  gec_edge_accum #(.CNT_W(CNT_W)) u_accum (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode),
    .boundary_i  (boundary),
    .next_free_i (next_free),
    .rise_i      (rise),
    .rd_ack      (rd_ack),
    .count_o     (live_count_o),
    .result_o    (result_o),
    .valid_o     (valid_o),
    .overrun_o   (overrun_o)
  );
endmodule

// File: rtl/gated_edge_counter_chk.sv
module gated_edge_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             rd_ack,
  input logic [CNT_W-1:0] result_o,
  input logic [CNT_W-1:0] live_count_o,
  input logic             valid_o,
  input logic             overrun_o
);
  logic rst_seen;
  initial rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= rst;

  // R1: outputs are zero after every clock edge that saw reset.
  always @(negedge clk) begin
    if (rst_seen) begin
      a_r1_reset_clear: assert (!valid_o && !overrun_o && result_o == '0 && live_count_o == '0)
        else $error("R1 outputs not cleared by reset");
    end
  end

  // R7: the overrun flag is sticky.
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  // R7: overrun only rises when an unread result was present.
  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(valid_o));

  // R6: valid only falls after a read strobe.
  a_r6_valid_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_o) |-> $past(rd_ack));

  // R2: a new result is always flagged valid.
  a_r2_store_valid: assert property (@(posedge clk) disable iff (rst)
    $changed(result_o) |-> valid_o);

  // R9: disabled means the live count is held at zero.
  a_r9_off_zero: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (live_count_o == '0));
endmodule

bind gated_edge_counter gated_edge_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .rd_ack       (rd_ack),
  .result_o     (result_o),
  .live_count_o (live_count_o),
  .valid_o      (valid_o),
  .overrun_o    (overrun_o)
);

// File: tb/gated_edge_counter_tb_top.sv
module gated_edge_counter_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sig = 1'b0;
  logic        en  = 1'b0;
  logic [31:0] period = '0;
  logic        rd  = 1'b0;
  logic [31:0] result, live;
  logic        valid, ovr;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gated_edge_counter dut_i (
    .clk(clk), .rst(rst), .sig_in(sig), .enable(en), .period_in(period),
    .rd_ack(rd), .result_o(result), .live_count_o(live), .valid_o(valid),
    .overrun_o(ovr)
  );

  // Reference model of the requirements, stepped on the same edges.
  logic [2:0]  m_sh;
  logic [31:0] m_len, m_tick, m_cnt, m_res;
  logic        m_val, m_ovr;
  wire         m_rise = m_sh[1] & ~m_sh[2];

  always @(posedge clk) begin
    if (rst) begin
      m_sh <= '0; m_len <= '0; m_tick <= '0; m_cnt <= '0;
      m_res <= '0; m_val <= 1'b0; m_ovr <= 1'b0;
    end else begin
      m_sh <= {m_sh[1:0], sig};
      if (!en) begin
        m_cnt <= '0; m_len <= period; m_tick <= '0;
        if (rd) m_val <= 1'b0;
      end else if (m_len == 0) begin
        m_cnt <= (period == 0) ? m_cnt + 32'(m_rise) : 32'(m_rise);
        m_len <= period; m_tick <= '0;
        if (rd) m_val <= 1'b0;
      end else if (m_tick == m_len - 1) begin
        m_res <= m_cnt; m_val <= 1'b1;
        if (m_val && !rd) m_ovr <= 1'b1;
        m_cnt <= 32'(m_rise); m_len <= period; m_tick <= '0;
      end else begin
        m_cnt <= m_cnt + 32'(m_rise); m_tick <= m_tick + 1;
        if (rd) m_val <= 1'b0;
      end
    end
  end

  function automatic bit differs(input logic [31:0] a, input logic [31:0] b);
    return a !== b;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (differs(act, exp)) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2/R8 result", result, m_res);
      check("R4/R5 live count", live, m_cnt);
      check("R6 valid", 32'(valid), 32'(m_val));
      check("R7 overrun", 32'(ovr), 32'(m_ovr));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; rd = 1'b0; sig = 1'b0; period = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_store(output int at);
    do @(negedge clk); while (!valid);
    at = cyc;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2, sum, edges;

    // R1: reset state.
    @(negedge clk); @(negedge clk);
    check("R1 result", result, 0);
    check("R1 live", live, 0);
    check("R1 valid", 32'(valid), 0);
    check("R1 overrun", 32'(ovr), 0);
    rst = 1'b0;

    // R4 and R5: latency in free-running mode.
    en = 1'b1; period = 0;
    @(negedge clk); sig = 1'b1;
    @(negedge clk); check("R4 edge+1", live, 0);
    @(negedge clk); check("R4 edge+2", live, 0);
    @(negedge clk); check("R4 edge+3", live, 1);
    repeat (5) @(negedge clk);
    check("R4 level once", live, 1);
    sig = 1'b0; repeat (4) @(negedge clk);
    check("R4 fall ignored", live, 1);
    for (int i = 0; i < 10; i++) begin
      sig = 1'b1; @(negedge clk); sig = 1'b0; @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R5 accumulate", live, 11);

    // R9: disable holds count at zero and makes no store.
    en = 1'b0; sig = 1'b1; repeat (5) @(negedge clk);
    check("R9 live zero", live, 0);
    check("R9 no store", 32'(valid), 0);

    // R8: gate length change waits for the next boundary.
    do_reset();
    period = 6; en = 1'b1;
    wait_store(t0);
    period = 3;
    wait_store(t1);
    wait_store(t2);
    check("R8 old length kept", 32'(t1 - t0), 6);
    check("R8 new length used", 32'(t2 - t1), 3);

    // R3: conservation of edges with edges landing on boundaries.
    do_reset();
    period = 5; en = 1'b1; sum = 0; edges = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (valid) sum += int'(result);
      rd = valid;
      if (i < 360) begin
        if (!sig) edges++;
        sig = ~sig;
      end else sig = 1'b0;
    end
    @(negedge clk); rd = 1'b0;
    if (valid) sum += int'(result);
    check("R3 edge total", 32'(sum) + live, 32'(edges));
    check("R7 no overrun when read", 32'(ovr), 0);

    // R7: unread results overwritten.
    do_reset();
    period = 2; en = 1'b1;
    sig = 1'b1; repeat (7) @(negedge clk);
    check("R7 overrun set", 32'(ovr), 1);
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    check("R7 overrun sticky", 32'(ovr), 1);

    // Randomized mix checked by the model every cycle.
    do_reset();
    void'($urandom(32'h5eed_1234));
    en = 1'b1; period = 4;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) sig = ~sig;
      rd = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 60) == 0) begin
        case ($urandom_range(0, 5))
          0: period = 0;
          1: period = 1;
          2: period = 2;
          3: period = 3;
          4: period = 7;
          default: period = 11;
        endcase
      end
      if ($urandom_range(0, 200) == 0) en = ~en;
      if (!en && $urandom_range(0, 4) == 0) en = 1'b1;
      if (i == 2000) begin
        do_reset();
        en = 1'b1; period = 5;
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule